// File: doc/BRIEF.md
# Serial-Serviced Window Watchdog

This block supervises software through a window watchdog. The service request is not a dedicated pin. It travels as the least significant bit of a serial command word. An external shifter passes that bit in on `svc_bit_i`. The service counts only in the cycle in which the same shifter signals the chip-select rising edge on `cs_rise_i`, which is when the frame is committed. A bit that is still being shifted in has no effect.

Time is measured in strobes on `tick_i`. The watchdog moves through three supervision phases:

- A closed window, in which servicing is forbidden.
- A normal open window, in which servicing is expected.
- A longer open window, which is used after start-up, after a wake request, and after a reset pulse.

Servicing inside the closed window, or failing to service before an open window expires, starts a reset pulse of fixed length on `wdt_rst_o`. The current phase is always visible as a 2-bit code on `phase_o`.

Top module: `spi_window_wdt`

## Requirements
- R1: After `rst_ni` is released, the block is in the long open phase: `phase_o` = 2 and `wdt_rst_o` = 0.
- R2: A service is a cycle in which both `cs_rise_i` and `svc_bit_i` are 1. A `cs_rise_i` with `svc_bit_i` = 0, or `svc_bit_i` = 1 without `cs_rise_i`, leaves the phase and its count unchanged.
- R3: A service while in the closed phase (code 0) moves the block to the reset phase (code 3) on the next clock edge, with `wdt_rst_o` = 1.
- R4: The closed phase lasts CLOSED_TICKS ticks (default 13). The edge that counts its last tick enters the open phase (code 1).
- R5: In the open phase, when OPEN_TICKS ticks (default 20) pass with no service, the block enters the reset phase on the edge of the last tick.
- R6: In the long open phase, when LONG_TICKS ticks (default 128) pass with no service, the block enters the reset phase on the edge of the last tick.
- R7: A service in the open phase or the long open phase moves the block to the closed phase, and the closed count starts from zero.
- R8: The reset phase lasts PULSE_TICKS ticks (default 8) and then enters the long open phase. During the reset phase, services and wake requests have no effect.
- R9: Outside the reset phase, a `long_req_i` pulse with no service in the same cycle enters the long open phase with a fresh count. A service in the same cycle takes priority.
- R10: `phase_o` encodes the phase as closed = 0, open = 1, long open = 2, reset = 3. `wdt_rst_o` is 1 exactly in phase 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe, one cycle per tick |
| svc_bit_i | input | 1 | Received bit 0 of the serial word |
| cs_rise_i | input | 1 | One-cycle chip-select low-to-high event |
| long_req_i | input | 1 | Wake request: enter the long open window |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| phase_o | output | 2 | Phase code, see R10 |

## Verification
The bench sweeps the number of ticks between two services from zero up to one tick beyond the end of the open window. This catches an off-by-one at either window edge. Such a design would pass a service on tick 12 or 13 of the closed window, or it would time out one tick early or late in the open window.

Further directed checks cover the following cases:
- The long window expiring exactly at its last tick.
- A reset pulse that is one tick too long or too short.
- Services and wake requests that wrongly shorten the pulse.
- A service committed without chip-select, or a chip-select with bit 0 clear, being accepted.
- A wake request that does not restart the count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PH_CLOSED = 2'd0,
    PH_OPEN   = 2'd1,
    PH_LONG   = 2'd2,
    PH_RESET  = 2'd3
  } phase_e;
endpackage

// File: rtl/wdt_svc_qual.sv
module wdt_svc_qual (
  input  logic svc_bit_i,
  input  logic cs_rise_i,
  output logic svc_o
);
  // service commits only at frame end
  assign svc_o = cs_rise_i & svc_bit_i;
endmodule

// File: rtl/wdt_tick_cnt.sv
module wdt_tick_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = (cnt_q == limit_i - CW'(1));

  AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i); // R4
endmodule

// File: rtl/wdt_phase_fsm.sv
module wdt_phase_fsm
  import wdt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   svc_i,
  input  logic   long_req_i,
  input  logic   tick_i,
  input  logic   last_i,
  output phase_e phase_o,
  output logic   clr_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (ph_q == PH_RESET) begin
      if (tick_i && last_i) ph_d = PH_LONG;
    end else if (svc_i) begin
      ph_d = (ph_q == PH_CLOSED) ? PH_RESET : PH_CLOSED;
    end else if (long_req_i) begin
      ph_d = PH_LONG;
    end else if (tick_i && last_i) begin
      ph_d = (ph_q == PH_CLOSED) ? PH_OPEN : PH_RESET;
    end
  end

  // restart count on any phase change or wake
  assign clr_o = (ph_d != ph_q) || (ph_q != PH_RESET && !svc_i && long_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_LONG;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;

  AST_EARLY_SVC_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_CLOSED && svc_i) |=> (ph_q == PH_RESET)); // R3
  AST_GOOD_SVC_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_OPEN || ph_q == PH_LONG) && svc_i) |=> (ph_q == PH_CLOSED)); // R7
  AST_PULSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RESET && !(tick_i && last_i)) |=> (ph_q == PH_RESET)); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!svc_i && !long_req_i && !tick_i) |=> $stable(ph_q)); // R2
  AST_WAKE_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_RESET && !svc_i && long_req_i) |=> (ph_q == PH_LONG)); // R9
endmodule

// File: rtl/spi_window_wdt.sv
module spi_window_wdt
  import wdt_pkg::*;
#(
  parameter int CLOSED_TICKS = 13,
  parameter int OPEN_TICKS   = 20,
  parameter int LONG_TICKS   = 128,
  parameter int PULSE_TICKS  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       svc_bit_i,
  input  logic       cs_rise_i,
  input  logic       long_req_i,
  output logic       wdt_rst_o,
  output logic [1:0] phase_o
);
  localparam int MAX_A = (CLOSED_TICKS > OPEN_TICKS) ? CLOSED_TICKS : OPEN_TICKS;
  localparam int MAX_B = (LONG_TICKS > PULSE_TICKS) ? LONG_TICKS : PULSE_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_T + 1);

  logic          svc, clr, last;
  phase_e        ph;
  logic [CW-1:0] limit;

  wdt_svc_qual u_qual (
    .svc_bit_i (svc_bit_i),
    .cs_rise_i (cs_rise_i),
    .svc_o     (svc)
  );

  always_comb begin
    unique case (ph)
      PH_CLOSED: limit = CW'(CLOSED_TICKS);
      PH_OPEN:   limit = CW'(OPEN_TICKS);
      PH_LONG:   limit = CW'(LONG_TICKS);
      default:   limit = CW'(PULSE_TICKS);
    endcase
  end

  wdt_tick_cnt #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (tick_i),
    .limit_i (limit),
    .last_o  (last)
  );

  wdt_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .svc_i      (svc),
    .long_req_i (long_req_i),
    .tick_i     (tick_i),
    .last_i     (last),
    .phase_o    (ph),
    .clr_o      (clr)
  );

  assign phase_o   = ph;
  assign wdt_rst_o = (ph == PH_RESET);

  AST_PULSE_ENDS_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> (phase_o == 2'd2)); // R8
endmodule

// File: tb/tb_spi_window_wdt.sv
module tb_spi_window_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int CLOSED = 13, OPEN = 20, LONG = 128, PULSE = 8;

  logic clk = 0, rst_n = 0;
  logic tick = 0, sbit = 0, csr = 0, lreq = 0;
  logic wrst;
  logic [1:0] ph;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_window_wdt dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .svc_bit_i(sbit),
    .cs_rise_i(csr), .long_req_i(lreq), .wdt_rst_o(wrst), .phase_o(ph)
  );

  task automatic cyc(input logic t, input logic b, input logic c, input logic l);
    tick = t; sbit = b; csr = c; lreq = l;
    @(negedge clk);
    tick = 0; sbit = 0; csr = 0; lreq = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic expect_ph(input int exp, input string req);
    checks++;
    if (ph !== 2'(exp) || wrst !== (exp == 3)) begin
      fails++;
      $display("FAIL %s: phase=%0d rst=%0b expected phase=%0d rst=%0b", req, ph, wrst, exp, exp == 3);
    end
  endtask

  task automatic to_long();
    if (ph == 2'd3) ticks(PULSE);
    cyc(0, 0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_ph(2, "R1");

    // sweep: k ticks after a good service, then service again
    for (int k = 0; k <= CLOSED + OPEN; k++) begin
      to_long();
      cyc(0, 1, 1, 0);
      expect_ph(0, "R7");
      ticks(k);
      expect_ph(k < CLOSED ? 0 : (k < CLOSED + OPEN ? 1 : 3), "R4/R5 window edge");
      cyc(0, 1, 1, 0);
      expect_ph(k < CLOSED ? 3 : (k < CLOSED + OPEN ? 0 : 3), "R3/R7/R8 service outcome");
    end

    // R6: long window expiry
    to_long();
    ticks(LONG - 1);
    expect_ph(2, "R6 before expiry");
    ticks(1);
    expect_ph(3, "R6 expiry");

    // R8: pulse length, ignores services and wakes
    ticks(PULSE - 1);
    cyc(0, 1, 1, 0);
    cyc(0, 0, 0, 1);
    expect_ph(3, "R8 pulse ignores service/wake");
    ticks(1);
    expect_ph(2, "R8 pulse end");

    // R2: non-services in closed and open phases
    cyc(0, 1, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 0);
    expect_ph(0, "R2 closed no trigger");
    ticks(CLOSED - 1);
    expect_ph(0, "R2 closed count kept");
    ticks(1);
    expect_ph(1, "R4 open entry");
    cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 0);
    expect_ph(1, "R2 open no trigger");
    ticks(OPEN - 1);
    expect_ph(1, "R2 open count kept");

    // R9: wake restarts long window with fresh count
    cyc(0, 0, 0, 1);
    expect_ph(2, "R9 wake");
    ticks(LONG - 1);
    cyc(0, 0, 0, 1);
    ticks(LONG - 1);
    expect_ph(2, "R9 fresh count");
    cyc(0, 1, 1, 1);
    expect_ph(0, "R9 service priority");
    cyc(0, 0, 0, 1);
    expect_ph(2, "R9 wake from closed");
    ticks(1);
    expect_ph(2, "R10 long code");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule